// File: doc/BRIEF.md
# Dual-Clock Packet Handoff Buffer

This block moves fixed-size packets of bytes from one clock domain to another. The producer runs on its own clock. It writes bytes one per enabled cycle into a small storage array, then marks the packet as finished with a single-cycle end strobe. The consumer runs on an unrelated clock. It learns that the packet is finished through one synchronized event. It then reads out the whole packet from the first entry to the last as a burst of valid beats, followed by a one-cycle completion pulse.

Only one event crosses between the domains. No pointer does. This is safe because the producer does not write while the consumer drains. Each packet fills the array exactly, so the write address wraps back to zero at the end of every packet. The array output is registered, which lets it map to block memory, and the valid timing allows for that cycle of read latency.

Top module: `pkt_xfer_buf`

## Requirements
- R1: While either reset is low, and after it is released until a packet event has crossed, rd_valid and rd_done are 0.
- R2: Each wr_clk edge with wr_en high stores wr_data at the current write address, and the address then advances by one. The first write after wr_rst_n is released goes to address 0, and the address wraps from DEPTH-1 to 0.
- R3: A wr_pkt_end strobe that is high for a single wr_clk cycle is always seen by the read domain, even when rd_clk is slower than wr_clk.
- R4: Each accepted packet event produces exactly DEPTH (32) consecutive read cycles with rd_valid high.
- R5: On the k-th valid beat of a drain (counting from 0), rd_data equals the byte stored at address k. A packet of DEPTH writes is therefore returned in the order it was written.
- R6: rd_done is high for exactly one read cycle. That cycle immediately follows the last valid beat, and rd_valid is low in it.
- R7: A wr_pkt_end event that reaches the read domain while a drain is in progress is dropped. No further valid beats follow that drain until a later event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer asynchronous reset, active low |
| wr_en | input | 1 | Store wr_data this cycle |
| wr_data | input | DATA_W (8) | Byte to store |
| wr_pkt_end | input | 1 | Strobe: the current packet is finished |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer asynchronous reset, active low |
| rd_data | output | DATA_W (8) | Byte read from the array, registered |
| rd_valid | output | 1 | rd_data carries a packet byte |
| rd_done | output | 1 | One-cycle pulse after the final beat |

## Verification
After a wr_pkt_end strobe, the drain begins a few read cycles later. The exact count depends on the synchronizer depth and on the phase between the two clocks, so the bench waits for it with a bounded timeout and does not fix the cycle. Once a drain has started, every result is tied to the read clock. Each beat's byte appears in the same cycle as its rd_valid, one cycle after the internal read address is issued. rd_done comes exactly one read cycle after the final beat. The bench samples on the falling edge of rd_clk and checks each beat against its position in the packet. It requires rd_done in exactly the sample that follows beat 31, and it watches for a long quiet window after a dropped event.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
   typedef enum logic {
      RD_IDLE  = 1'b0,
      RD_DRAIN = 1'b1
   } rd_state_e;
endpackage

// File: rtl/pxb_wr_ctrl.sv
module pxb_wr_ctrl #(
   parameter int AW = 5
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_en,
   input  logic          pkt_end,
   output logic [AW-1:0] wr_ptr,
   output logic          pkt_tgl
);
   // Address register: asynchronous reset, wraps naturally at 2**AW
   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n)   wr_ptr <= '0;
      else if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
   end

   // A level that flips once per packet, so a short strobe survives a slow reader
   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n)    pkt_tgl <= 1'b0;
      else if (pkt_end) pkt_tgl <= ~pkt_tgl;
   end
endmodule

// File: rtl/pxb_store.sv
module pxb_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   parameter int AW     = 5
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_ptr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   // Array write kept apart from any reset
   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   // Registered read port, no reset, so block memory can be used
   always_ff @(posedge rd_clk) begin
      if (rd_en) rd_data <= mem[rd_ptr];
   end
endmodule

// File: rtl/pxb_evt_sync.sv
module pxb_evt_sync #(
   parameter int STAGES = 4
) (
   input  logic rd_clk,
   input  logic tgl_in,
   output logic evt
);
   logic [STAGES-1:0] chain;

   // Reset-free chain so it can map to shift-register cells
   always_ff @(posedge rd_clk) begin
      chain[0] <= tgl_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge rd_clk) begin
         chain[s] <= chain[s-1];
      end
   end

   // Change between the two oldest stages marks one packet event
   assign evt = chain[STAGES-1] ^ chain[STAGES-2];
endmodule

// File: rtl/pxb_rd_ctrl.sv
module pxb_rd_ctrl
   import pxb_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int AW    = 5
) (
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          evt,
   output logic          rd_en,
   output logic [AW-1:0] rd_ptr,
   output logic          rd_valid,
   output logic          rd_done
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   rd_state_e state;
   logic      last_q;

   assign rd_en = (state == RD_DRAIN);

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         state  <= RD_IDLE;
         rd_ptr <= '0;
      end else begin
         case (state)
            RD_IDLE: begin
               if (evt) begin
                  state  <= RD_DRAIN;
                  rd_ptr <= '0;
               end
            end
            RD_DRAIN: begin
               // events seen here are dropped
               rd_ptr <= rd_ptr + 1'b1;
               if (rd_ptr == LAST) state <= RD_IDLE;
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   // Valid lines up with the registered array output
   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rd_valid <= 1'b0;
         last_q   <= 1'b0;
         rd_done  <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         last_q   <= rd_en && (rd_ptr == LAST);
         rd_done  <= last_q;
      end
   end
endmodule

// File: rtl/pkt_xfer_buf.sv
module pkt_xfer_buf #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 32,
   parameter int SYNC_STAGES = 4
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_pkt_end,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_done
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("pkt_xfer_buf: DEPTH must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 3) begin : g_bad_sync
      $error("pkt_xfer_buf: SYNC_STAGES must be at least 3");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pkt_xfer_buf: DATA_W must be positive");
   end

   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic          pkt_tgl;
   logic          evt;
   logic          rd_en;

   pxb_wr_ctrl #(.AW(AW)) u_wr (
      .wr_clk  (wr_clk),
      .wr_rst_n(wr_rst_n),
      .wr_en   (wr_en),
      .pkt_end (wr_pkt_end),
      .wr_ptr  (wr_ptr),
      .pkt_tgl (pkt_tgl)
   );

   pxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .wr_clk (wr_clk),
      .wr_en  (wr_en),
      .wr_ptr (wr_ptr),
      .wr_data(wr_data),
      .rd_clk (rd_clk),
      .rd_en  (rd_en),
      .rd_ptr (rd_ptr),
      .rd_data(rd_data)
   );

   pxb_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .rd_clk(rd_clk),
      .tgl_in(pkt_tgl),
      .evt   (evt)
   );

   pxb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
      .rd_clk  (rd_clk),
      .rd_rst_n(rd_rst_n),
      .evt     (evt),
      .rd_en   (rd_en),
      .rd_ptr  (rd_ptr),
      .rd_valid(rd_valid),
      .rd_done (rd_done)
   );
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
   parameter int DEPTH = 32
) (
   input logic rd_clk,
   input logic rd_rst_n,
   input logic rd_valid,
   input logic rd_done
);
   localparam int CW = $clog2(DEPTH) + 1;

   // Length of the current (or just ended) run of valid beats
   logic [CW-1:0] run;
   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n)     run <= '0;
      else if (rd_valid) run <= run + 1'b1;
      else               run <= '0;
   end

   a_r4_run_length: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (!rd_valid && run != '0) |-> (run == CW'(DEPTH)));

   a_r4_run_bounded: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_valid |-> (run < CW'(DEPTH)));

   a_r6_done_alone: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_done |-> !rd_valid);

   a_r6_done_follows_last: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_done |-> (run == CW'(DEPTH)));

   a_r6_done_single: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_done |=> !rd_done);

   a_r1_reset_quiet: assert property (@(posedge rd_clk)
      !rd_rst_n |-> (!rd_valid && !rd_done));
endmodule

bind pkt_xfer_buf pxb_checker #(.DEPTH(DEPTH)) u_chk (
   .rd_clk  (rd_clk),
   .rd_rst_n(rd_rst_n),
   .rd_valid(rd_valid),
   .rd_done (rd_done)
);

// File: tb/tb_pkt_xfer_buf.sv
module tb_pkt_xfer_buf;
   localparam int DW    = 8;
   localparam int DEPTH = 32;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          wr_rst_n = 1'b0;
   logic          rd_rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_pkt_end = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          rd_done;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_mem [DEPTH];
   int beat = 0;
   int done_cnt = 0;
   int valid_total = 0;
   logic prev_valid = 1'b0;
   logic mon_on = 1'b0;

   always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
   always #4.0 rd_clk = ~rd_clk;   // slower read clock

   pkt_xfer_buf #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(4)) dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_pkt_end(wr_pkt_end), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pattern(input int mode, input int idx);
      case (mode)
         0:       return DW'(idx);
         1:       return (idx % 2 == 0) ? 8'hFF : 8'h00;
         default: return DW'($urandom);
      endcase
   endfunction

   // Read-side monitor, sampled away from the rising edge
   always @(negedge rd_clk) begin
      if (mon_on) begin
         if (rd_valid) begin
            valid_total++;
            if (beat < DEPTH)
               check(rd_data == exp_mem[beat], "R5 byte order", int'(rd_data), int'(exp_mem[beat]));
            else
               check(1'b0, "R4 beat count", beat + 1, DEPTH);
            beat++;
         end
         if (rd_done) begin
            check(!rd_valid, "R6 done without valid", int'(rd_valid), 0);
            check(prev_valid && beat == DEPTH, "R6 done after last beat", beat, DEPTH);
            done_cnt++;
            beat = 0;
         end else if (prev_valid && !rd_valid) begin
            check(1'b0, "R6 done missing after last beat", 0, 1);
         end
         if (!rd_valid && !rd_done && beat != 0) begin
            check(1'b0, "R4 burst broken", beat, DEPTH);
            beat = 0;
         end
         prev_valid = rd_valid;
      end
   end

   task automatic send_packet(input int mode, input bit gaps);
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = pattern(mode, i);
      for (int i = 0; i < DEPTH; i++) begin
         if (gaps) begin
            int idle = int'($urandom % 4);
            for (int g = 0; g < idle; g++) @(negedge wr_clk);
         end
         @(negedge wr_clk);
         wr_en   = 1'b1;
         wr_data = exp_mem[i];
         @(negedge wr_clk);
         wr_en   = 1'b0;
         wr_data = DW'($urandom);
      end
      pulse_end();
   endtask

   task automatic pulse_end();
      @(negedge wr_clk);
      wr_pkt_end = 1'b1;
      @(negedge wr_clk);
      wr_pkt_end = 1'b0;
   endtask

   task automatic wait_done(input int target, input string req);
      int n = 0;
      while (done_cnt < target && n < 400) begin
         @(negedge rd_clk);
         n++;
      end
      check(done_cnt == target, req, done_cnt, target);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge rd_clk);
      // R1: outputs quiet in reset
      check(!rd_valid && !rd_done, "R1 quiet in reset", int'({rd_valid, rd_done}), 0);
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      mon_on   = 1'b1;
      repeat (10) @(negedge rd_clk);
      check(valid_total == 0 && done_cnt == 0, "R1 quiet after reset", valid_total, 0);

      // R2 R3 R4 R5: address order, single-cycle end strobe, burst length
      send_packet(0, 1'b0);
      wait_done(1, "R3 packet event crossed");
      check(valid_total == DEPTH, "R4 beats per packet", valid_total, DEPTH);

      // R2: wrap back to address 0 for the next packet, alternating bytes
      send_packet(1, 1'b1);
      wait_done(2, "R2 wrap to address 0");

      // R7: an end strobe during the drain is dropped
      send_packet(2, 1'b1);
      while (!rd_valid) @(negedge rd_clk);
      pulse_end();
      wait_done(3, "R7 drain completes");
      repeat (60) @(negedge rd_clk);
      check(valid_total == 3 * DEPTH, "R7 dropped event makes no beats", valid_total, 3 * DEPTH);
      check(done_cnt == 3, "R7 no extra done", done_cnt, 3);

      // Random packets, with and without write gaps
      for (int p = 0; p < 6; p++) begin
         send_packet(2, p[0]);
         wait_done(4 + p, "R5 random packet");
      end
      check(valid_total == 9 * DEPTH, "R4 total beats", valid_total, 9 * DEPTH);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule